// File: doc/BRIEF.md
# Capability Instruction Decoder

This block examines a 32-bit RISC-V instruction word and decides whether the capability extension owns it. When it does, it names the operation and passes on the register indices and both readings of the 12-bit immediate, one sign-extended and one zero-extended. For capability loads and stores it also says where the base capability comes from. In capability mode the base is the register named by rs1. In integer mode the base is the default data capability, and its address is moved by the integer rs1 plus the immediate.

The decode itself is combinational. Its result is held in one output register stage with a valid/ready handshake, so a stalled consumer keeps the last decoded result steady. Register file access, memory traffic and execution belong to neighbouring blocks.

Top module: `capdec`

## Requirements
- R1: The claim flag is 1 for every instruction with major opcode 7'h5B, for major opcode 7'h0F with funct3 2, and for major opcode 7'h23 with funct3 4. It is 0 for all other instructions. When the claim flag is 0, both the op code and the illegal flag are 0.
- R2: Opcode 7'h5B with funct3 0 decodes by funct7 as follows: 0x08 gives op 1 (set bounds), 0x09 gives op 2 (set bounds exact), 0x11 gives op 4 (add offset) and 0x13 gives op 6 (from pointer).
- R3: Opcode 7'h5B with funct3 2 gives op 3 (set bounds by immediate) and funct3 1 gives op 5 (add immediate offset), whatever funct7 holds. The immediate is instr[31:20]. It is output sign-extended to 64 bits on imm_s and zero-extended on imm_u.
- R4: When funct3 is 0 and funct7 is 0x7F, the rs2 field selects a unary operation: 0x04 gives op 7 (read tag), 0x0A gives op 8 (move) and 0x0C gives op 9 (jump and link).
- R5: When funct3 is 0, funct7 0x7D with rs2 0x0B gives op 12 (64-bit load via capability), and funct7 0x7C with rd 0x0B gives op 13 (64-bit store via capability). Both of these always take their base from the capability register, so base_ddc is 0.
- R6: A capability load (opcode 0x0F) gives op 10 and a capability store (opcode 0x23) gives op 11. For either one, base_ddc equals int_mode: 1 means the default data capability is the base, and 0 means register rs1 is the base. A store's immediate is {instr[31:25], instr[11:7]}. base_ddc is 0 for every other op.
- R7: Any claimed instruction whose funct7/funct3/rs2/rd combination is not listed above sets the illegal flag to 1, keeps the claim flag at 1 and gives op 0.
- R8: After reset, out_valid is 0. An input is accepted on a clock edge when in_valid and in_ready are both 1, and its result shows on the outputs after that edge. in_ready equals (!out_valid || out_ready). While out_valid is 1 and out_ready is 0, every output holds its value.
- R9: rd, rs1 and rs2 are output from instr[11:7], instr[19:15] and instr[24:20] without change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Stage can accept |
| instr | input | 32 | Instruction word |
| int_mode | input | 1 | 1 = integer addressing mode |
| out_valid | output | 1 | Decoded result present |
| out_ready | input | 1 | Consumer takes result |
| out_claim | output | 1 | Extension owns the instruction |
| out_illegal | output | 1 | Claimed but not a valid combination |
| out_op | output | 4 | Operation code |
| out_rd | output | 5 | Destination index |
| out_rs1 | output | 5 | First source index |
| out_rs2 | output | 5 | Second source index |
| out_imm_s | output | 64 | Sign-extended immediate |
| out_imm_u | output | 64 | Zero-extended immediate |
| out_base_ddc | output | 1 | Base is the default data capability |

## Verification
The assertions assume that the consumer may hold out_ready low for any length of time. They also assume that in_valid, instr and int_mode are known at every clock edge after reset; these inputs are not required to hold while the stage is stalled. The bench drives every input at the falling edge, so values never change at the sampling edge. Outside an instruction, it keeps in_valid low and the instruction word at a known value.

// File: rtl/capdec.sv
module capdec #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     instr,
  input  logic            int_mode,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_claim,
  output logic            out_illegal,
  output logic [3:0]      out_op,
  output logic [4:0]      out_rd,
  output logic [4:0]      out_rs1,
  output logic [4:0]      out_rs2,
  output logic [XLEN-1:0] out_imm_s,
  output logic [XLEN-1:0] out_imm_u,
  output logic            out_base_ddc
);
  localparam logic [6:0] OPC_CUST = 7'h5B;
  localparam logic [6:0] OPC_MISC = 7'h0F;
  localparam logic [6:0] OPC_STOR = 7'h23;

  typedef enum logic [3:0] {
    K_NONE = 4'd0, K_SETB = 4'd1, K_SETBX = 4'd2, K_SETBI = 4'd3,
    K_ADDO = 4'd4, K_ADDOI = 4'd5, K_FPTR = 4'd6, K_TAG = 4'd7,
    K_MOVE = 4'd8, K_JAL = 4'd9, K_LDC = 4'd10, K_STC = 4'd11,
    K_LD64 = 4'd12, K_ST64 = 4'd13
  } kind_t;

  wire [6:0] opc = instr[6:0];
  wire [4:0] rd  = instr[11:7];
  wire [2:0] f3  = instr[14:12];
  wire [4:0] rs1 = instr[19:15];
  wire [4:0] rs2 = instr[24:20];
  wire [6:0] f7  = instr[31:25];

  wire [11:0] imm12 = (opc == OPC_STOR) ? {instr[31:25], instr[11:7]} : instr[31:20];

  logic  claim, ill, ddc;
  kind_t kind;

  always_comb begin
    claim = 1'b0;
    ill   = 1'b0;
    ddc   = 1'b0;
    kind  = K_NONE;
    case (opc)
      OPC_CUST: begin
        claim = 1'b1;
        case (f3)
          3'd0: case (f7)
            7'h08: kind = K_SETB;
            7'h09: kind = K_SETBX;
            7'h11: kind = K_ADDO;
            7'h13: kind = K_FPTR;
            7'h7F: case (rs2)
              5'h04:   kind = K_TAG;
              5'h0A:   kind = K_MOVE;
              5'h0C:   kind = K_JAL;
              default: ill = 1'b1;
            endcase
            7'h7D: if (rs2 == 5'h0B) kind = K_LD64; else ill = 1'b1;
            7'h7C: if (rd == 5'h0B) kind = K_ST64; else ill = 1'b1;
            default: ill = 1'b1;
          endcase
          3'd1:    kind = K_ADDOI;
          3'd2:    kind = K_SETBI;
          default: ill = 1'b1;
        endcase
      end
      OPC_MISC: if (f3 == 3'd2) begin
        claim = 1'b1;
        kind  = K_LDC;
        ddc   = int_mode;
      end
      OPC_STOR: if (f3 == 3'd4) begin
        claim = 1'b1;
        kind  = K_STC;
        ddc   = int_mode;
      end
      default: ;
    endcase
  end

  wire take = in_valid && in_ready;
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_claim    <= 1'b0;
      out_illegal  <= 1'b0;
      out_op       <= K_NONE;
      out_rd       <= '0;
      out_rs1      <= '0;
      out_rs2      <= '0;
      out_imm_s    <= '0;
      out_imm_u    <= '0;
      out_base_ddc <= 1'b0;
    end else if (take) begin
      out_valid    <= 1'b1;
      out_claim    <= claim;
      out_illegal  <= ill;
      out_op       <= kind;
      out_rd       <= rd;
      out_rs1      <= rs1;
      out_rs2      <= rs2;
      out_imm_s    <= {{(XLEN-12){imm12[11]}}, imm12};
      out_imm_u    <= {{(XLEN-12){1'b0}}, imm12};
      out_base_ddc <= ddc;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end
endmodule

module capdec_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [31:0]     instr,
  input logic            int_mode,
  input logic            out_valid,
  input logic            out_ready,
  input logic            out_claim,
  input logic            out_illegal,
  input logic [3:0]      out_op,
  input logic [4:0]      out_rd,
  input logic [4:0]      out_rs1,
  input logic [4:0]      out_rs2,
  input logic [XLEN-1:0] out_imm_s,
  input logic [XLEN-1:0] out_imm_u,
  input logic            out_base_ddc
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_op) && $stable(out_imm_s)
      && $stable(out_rd) && $stable(out_claim) && $stable(out_base_ddc));
  p_idle_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  p_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  p_ill_claimed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_claim && out_op == 4'd0);
  p_unclaimed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_claim |-> !out_illegal && out_op == 4'd0);
  p_ddc_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_base_ddc |-> (out_op == 4'd10 || out_op == 4'd11));
  p_imm_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_imm_s[11:0] == out_imm_u[11:0] && out_imm_u[XLEN-1:12] == '0);
endmodule

bind capdec capdec_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_capdec.sv
`timescale 1ns/1ps
module sim_capdec;
  logic clk = 0, rst_n = 0, in_valid = 0, int_mode = 0, out_ready = 1;
  logic [31:0] instr = 32'h13;
  logic in_ready, out_valid, out_claim, out_illegal, out_base_ddc;
  logic [3:0] out_op;
  logic [4:0] out_rd, out_rs1, out_rs2;
  logic [63:0] out_imm_s, out_imm_u;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  capdec u0 (.*);

  function automatic logic [31:0] enc(input logic [6:0] f7, input logic [4:0] r2,
      input logic [4:0] r1, input logic [2:0] f3, input logic [4:0] d, input logic [6:0] op);
    return {f7, r2, r1, f3, d, op};
  endfunction

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] i, input logic m);
    @(negedge clk); instr = i; int_mode = m; in_valid = 1;
    @(posedge clk); @(negedge clk); in_valid = 0;
  endtask

  task automatic t_reset;
    chk("R8 reset valid", out_valid, 0);
    chk("R8 reset ready", in_ready, 1);
  endtask

  task automatic t_claim;
    send(32'h0000_0013, 0);
    chk("R1 addi claim", out_claim, 0);
    chk("R1 addi op", out_op, 0);
    chk("R1 addi ill", out_illegal, 0);
    send(enc(7'h0, 5'h0, 5'h1, 3'd3, 5'h2, 7'h0F), 0);
    chk("R1 misc f3=3 claim", out_claim, 0);
    send(enc(7'h0, 5'h1, 5'h1, 3'd3, 5'h2, 7'h23), 0);
    chk("R1 store f3=3 claim", out_claim, 0);
    send(enc(7'h08, 5'h2, 5'h3, 3'd0, 5'h4, 7'h5B), 0);
    chk("R1 custom claim", out_claim, 1);
  endtask

  task automatic t_funct7;
    send(enc(7'h08, 5'h2, 5'h3, 3'd0, 5'h4, 7'h5B), 0); chk("R2 setb", out_op, 1);
    send(enc(7'h09, 5'h2, 5'h3, 3'd0, 5'h4, 7'h5B), 0); chk("R2 setbx", out_op, 2);
    send(enc(7'h11, 5'h2, 5'h3, 3'd0, 5'h4, 7'h5B), 0); chk("R2 addo", out_op, 4);
    send(enc(7'h13, 5'h2, 5'h3, 3'd0, 5'h4, 7'h5B), 0); chk("R2 fptr", out_op, 6);
    chk("R2 not ill", out_illegal, 0);
  endtask

  task automatic t_imm;
    send({12'hFFF, 5'h3, 3'd2, 5'h4, 7'h5B}, 0);
    chk("R3 setbi op", out_op, 3);
    chk("R3 imm_u", out_imm_u, 64'hFFF);
    chk("R3 imm_s", out_imm_s, 64'hFFFF_FFFF_FFFF_FFFF);
    send({12'h7F0, 5'h3, 3'd1, 5'h4, 7'h5B}, 0);
    chk("R3 addoi op", out_op, 5);
    chk("R3 imm_s pos", out_imm_s, 64'h7F0);
    send({12'h800, 5'h3, 3'd1, 5'h4, 7'h5B}, 0);
    chk("R3 imm_s neg", out_imm_s, 64'hFFFF_FFFF_FFFF_F800);
  endtask

  task automatic t_unary;
    send(enc(7'h7F, 5'h04, 5'h3, 3'd0, 5'h4, 7'h5B), 0); chk("R4 tag", out_op, 7);
    send(enc(7'h7F, 5'h0A, 5'h3, 3'd0, 5'h4, 7'h5B), 0); chk("R4 move", out_op, 8);
    send(enc(7'h7F, 5'h0C, 5'h3, 3'd0, 5'h4, 7'h5B), 0); chk("R4 jal", out_op, 9);
    send(enc(7'h7F, 5'h05, 5'h3, 3'd0, 5'h4, 7'h5B), 0); chk("R4 rs2=5 ill", out_illegal, 1);
  endtask

  task automatic t_mem64;
    send(enc(7'h7D, 5'h0B, 5'h3, 3'd0, 5'h4, 7'h5B), 1);
    chk("R5 ld64", out_op, 12);
    chk("R5 ld64 base", out_base_ddc, 0);
    send(enc(7'h7C, 5'h6, 5'h3, 3'd0, 5'h0B, 7'h5B), 1);
    chk("R5 st64", out_op, 13);
    chk("R5 st64 base", out_base_ddc, 0);
    send(enc(7'h7D, 5'h0A, 5'h3, 3'd0, 5'h4, 7'h5B), 0); chk("R5 ld rs2 ill", out_illegal, 1);
    send(enc(7'h7C, 5'h6, 5'h3, 3'd0, 5'h0A, 7'h5B), 0); chk("R5 st rd ill", out_illegal, 1);
  endtask

  task automatic t_base;
    send({12'hFF8, 5'h5, 3'd2, 5'h6, 7'h0F}, 0);
    chk("R6 ldc op", out_op, 10);
    chk("R6 ldc cap mode", out_base_ddc, 0);
    chk("R6 ldc imm", out_imm_s, 64'hFFFF_FFFF_FFFF_FFF8);
    send({12'hFF8, 5'h5, 3'd2, 5'h6, 7'h0F}, 1);
    chk("R6 ldc int mode", out_base_ddc, 1);
    send({7'h01, 5'h7, 5'h5, 3'd4, 5'h10, 7'h23}, 1);
    chk("R6 stc op", out_op, 11);
    chk("R6 stc int mode", out_base_ddc, 1);
    chk("R6 stc imm", out_imm_s, 64'h30);
    send(enc(7'h08, 5'h2, 5'h3, 3'd0, 5'h4, 7'h5B), 1);
    chk("R6 non-mem base", out_base_ddc, 0);
  endtask

  task automatic t_illegal;
    send(enc(7'h0B, 5'h2, 5'h3, 3'd0, 5'h4, 7'h5B), 0);
    chk("R7 f7 0b ill", out_illegal, 1);
    chk("R7 f7 0b claim", out_claim, 1);
    chk("R7 f7 0b op", out_op, 0);
    send(enc(7'h08, 5'h2, 5'h3, 3'd5, 5'h4, 7'h5B), 0);
    chk("R7 f3=5 ill", out_illegal, 1);
  endtask

  task automatic t_fields;
    send(enc(7'h08, 5'h15, 5'h0E, 3'd0, 5'h1F, 7'h5B), 0);
    chk("R9 rd", out_rd, 5'h1F);
    chk("R9 rs1", out_rs1, 5'h0E);
    chk("R9 rs2", out_rs2, 5'h15);
  endtask

  task automatic t_stall;
    @(negedge clk); out_ready = 0;
    send(enc(7'h09, 5'h2, 5'h3, 3'd0, 5'h4, 7'h5B), 0);
    chk("R8 stall valid", out_valid, 1);
    chk("R8 stall ready", in_ready, 0);
    instr = enc(7'h11, 5'h2, 5'h3, 3'd0, 5'h4, 7'h5B); in_valid = 1;
    @(posedge clk); @(negedge clk);
    chk("R8 held op", out_op, 2);
    out_ready = 1;
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    chk("R8 next op", out_op, 4);
    @(posedge clk); @(negedge clk);
    chk("R8 drain", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_claim;
    t_funct7;
    t_imm;
    t_unary;
    t_mem64;
    t_base;
    t_illegal;
    t_fields;
    t_stall;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule